// File: doc/BRIEF.md
# PHY Link Bring-up Sequencer

This block brings an Ethernet PHY out of reset and settles the operating speed and duplex for the MAC. It drives a simple request/acknowledge port towards an MDIO management controller. That controller performs the serial access and returns read data with a valid flag. The sequencer never handles the wire protocol itself.

After a start pulse, the sequencer can first look for the PHY. It reads the basic control register at each address and takes the first one that answers with a real value; if no address does, it uses a default. It then waits out any reset already in progress, issues a software reset that keeps the other control bits, and waits for that reset to finish. When autonegotiation is disabled, it forces 10 Mbit half duplex. Otherwise it polls for completion and then intersects local and partner abilities: gigabit first, then 100/10. A timeout turns a stuck reset into a failure. A stuck negotiation instead falls back to the forced speed bits of the control register.

The result appears as three mode bits laid out the way the MAC control word expects them. It is announced by a one-cycle done pulse and held until the next run.

Top module: `phy_link_seq`

## Requirements
- R1: With scanning enabled, register 0 is read at addresses 0 upwards and the first address returning a valid value other than 0x0000 and 0xFFFF is used. A read without the valid flag counts as 0xFFFF. If no address qualifies, or scanning is disabled, `dflt_addr` is used. The chosen address appears on `phy_addr`.
- R2: The sequencer first re-reads register 0 while bit 15 is set. It then writes register 0 with the value read, bit 15 set. It then re-reads until bit 15 reads clear.
- R3: If either reset wait is still seeing bit 15 once `TIMEOUT_CYC` cycles have passed since the end of the address phase, the run ends with `done` and `fail` high and `mac_ctrl` zero.
- R4: If register 0 bit 12 reads clear after the reset, register 0 is written with 0x0000 and the mode is 10 Mbit half duplex (`mac_ctrl` = 0).
- R5: Otherwise register 1 is polled until bit 5 is set. If the timeout passes first, register 0 is read and the mode is taken from it with `fail` low: gigabit = bit 6 and not bit 13, 100 Mbit = bit 13 and not bit 6, full duplex = bit 8.
- R6: If register 1 bit 8 is set, registers 9 and 10 are read. Register 9 bit 9 together with register 10 bit 11 gives gigabit full duplex. Register 9 bit 8 together with register 10 bit 10 gives gigabit half duplex, and this later match wins.
- R7: If gigabit was not reached, or the MAC is not gigabit capable, registers 4 and 5 are read and checked in this order, each later match overriding the earlier ones. Common bit 8 gives 100 full. Common bit 7 gives 100 half. Common bit 6 sets full duplex.
- R8: If gigabit was reached but `mac_gbit` is low, gigabit and full duplex are cleared and register 0 is written with only bit 13 carrying the 100 Mbit choice.
- R9: `mac_ctrl` carries gigabit in bit 8, 100 Mbit in bit 7 and full duplex in bit 4, all other bits zero.
- R10: At most one management request is outstanding. `mdio_req` is a one-cycle pulse. Address, register, direction and write data stay stable until `mdio_ack`.
- R11: `done` is a one-cycle pulse. `mac_ctrl`, `fail` and `phy_addr` hold until the next start. A start while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a bring-up run when idle |
| scan_en | input | 1 | Enables the address search |
| dflt_addr | input | 5 | Fallback PHY address |
| mac_gbit | input | 1 | MAC supports gigabit |
| mdio_req | output | 1 | Request pulse to the management controller |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Access finished |
| mdio_valid | input | 1 | Read data is valid |
| mdio_rdata | input | 16 | Read data |
| done | output | 1 | Run finished pulse |
| fail | output | 1 | Run ended on a reset timeout |
| phy_addr | output | 5 | Address in use |
| mac_ctrl | output | 9 | Mode bits for the MAC control word |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 600 and the full 0 to 31 scan range. With that short limit, both the failing reset path and the negotiation fallback finish within a few hundred cycles per run. Those runs sit between ordinary runs in which the PHY model answers at random addresses, with random latency and random ability sets. The full scan range lets the model hide the PHY behind addresses that answer 0x0000, 0xFFFF or nothing valid, and lets a run find no PHY at all.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // management register numbers
    localparam logic [ADDR_W-1:0] RN_CTL  = 5'd0;
    localparam logic [ADDR_W-1:0] RN_STS  = 5'd1;
    localparam logic [ADDR_W-1:0] RN_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] RN_LPA  = 5'd5;
    localparam logic [ADDR_W-1:0] RN_GADV = 5'd9;
    localparam logic [ADDR_W-1:0] RN_GLPA = 5'd10;

    // bit positions
    localparam int B_RST   = 15;
    localparam int B_SELHI = 13;
    localparam int B_ANEN  = 12;
    localparam int B_DUP   = 8;
    localparam int B_SELLO = 6;
    localparam int B_ANOK  = 5;
    localparam int B_EXT   = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RWAIT1,
        ST_RWR,
        ST_RWAIT2,
        ST_FORCE,
        ST_ANPOLL,
        ST_TORD,
        ST_G_LCL,
        ST_G_PRT,
        ST_F_LCL,
        ST_F_PRT,
        ST_DOWN,
        ST_FIN,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int LIMIT = 750_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (cnt_q == LIM)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);

    // R3/R5: once the window is used up it stays used up until cleared
    a_r5_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired);

endmodule

// File: rtl/phy_seq_resolve.sv
module phy_seq_resolve
    import phy_seq_pkg::*;
(
    input  logic [DATA_W-1:0] lcl,
    input  logic [DATA_W-1:0] prt,
    input  logic              gb_in,
    input  logic              fd_in,
    input  logic              mac_gbit,
    output logic              gig_hit,
    output logic              gig_fd,
    output logic              fast_gb,
    output logic              fast_sp,
    output logic              fast_fd,
    output logic              need_down
);
    logic g_full, g_half;
    logic f_full, f_half, t_full;

    // gigabit stage: local register 9 vs partner register 10
    assign g_full = lcl[9] & prt[11];
    assign g_half = lcl[8] & prt[10];

    always_comb begin
        gig_hit = 1'b0;
        gig_fd  = 1'b0;
        if (g_full) begin
            gig_hit = 1'b1;
            gig_fd  = 1'b1;
        end
        if (g_half) begin
            gig_hit = 1'b1;
            gig_fd  = 1'b0;
        end
    end

    // 10/100 stage: local register 4 vs partner register 5
    assign f_full = lcl[8] & prt[8];
    assign f_half = lcl[7] & prt[7];
    assign t_full = lcl[6] & prt[6];

    always_comb begin
        fast_gb   = gb_in;
        fast_sp   = 1'b0;
        fast_fd   = fd_in;
        need_down = 1'b0;
        if (f_full) begin
            fast_sp = 1'b1;
            fast_fd = 1'b1;
        end
        if (f_half) begin
            fast_sp = 1'b1;
            fast_fd = 1'b0;
        end
        if (t_full)
            fast_fd = 1'b1;
        if (gb_in && !mac_gbit) begin
            fast_gb   = 1'b0;
            fast_fd   = 1'b0;
            need_down = 1'b1;
        end
    end

endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
    import phy_seq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 750_000_000,
    parameter int SCAN_LAST   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              scan_en,
    input  logic [ADDR_W-1:0] dflt_addr,
    input  logic              mac_gbit,
    output logic              mdio_req,
    output logic              mdio_wr,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [ADDR_W-1:0] mdio_reg,
    output logic [DATA_W-1:0] mdio_wdata,
    input  logic              mdio_ack,
    input  logic              mdio_valid,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [8:0]        mac_ctrl
);
    localparam logic [ADDR_W-1:0] SCAN_END = ADDR_W'(SCAN_LAST);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        seq_state_e        st;
        logic              pend;
        logic              req;
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] wd;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] scan;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] abil;
        logic              gb;
        logic              sp;
        logic              fd;
        logic              done;
        logic              fail;
    } seq_t;

    seq_t s_d, s_q;

    logic [DATA_W-1:0] rd;
    logic              acc, a_wr, ack;
    logic [ADDR_W-1:0] a_reg, a_phy;
    logic [DATA_W-1:0] a_wd;
    logic              tmr_clr, tmr_exp;
    logic              gig_hit, gig_fd, fast_gb, fast_sp, fast_fd, need_down;

    // a read without the valid flag looks like an absent device
    assign rd = mdio_valid ? mdio_rdata : ALL_ONES;

    // the timeout window opens once the address phase is over
    assign tmr_clr = (s_q.st == ST_IDLE) || (s_q.st == ST_SCAN);

    phy_seq_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .expired (tmr_exp)
    );

    phy_seq_resolve i_resolve (
        .lcl       (s_q.abil),
        .prt       (rd),
        .gb_in     (s_q.gb),
        .fd_in     (s_q.fd),
        .mac_gbit  (mac_gbit),
        .gig_hit   (gig_hit),
        .gig_fd    (gig_fd),
        .fast_gb   (fast_gb),
        .fast_sp   (fast_sp),
        .fast_fd   (fast_fd),
        .need_down (need_down)
    );

    // which access each state performs
    always_comb begin
        acc   = 1'b1;
        a_wr  = 1'b0;
        a_reg = RN_CTL;
        a_wd  = '0;
        unique case (s_q.st)
            ST_SCAN, ST_RWAIT1, ST_RWAIT2, ST_TORD: a_reg = RN_CTL;
            ST_RWR: begin
                a_wr = 1'b1;
                a_wd = s_q.ctl | (DATA_W'(1) << B_RST);
            end
            ST_FORCE: a_wr = 1'b1;
            ST_ANPOLL: a_reg = RN_STS;
            ST_G_LCL:  a_reg = RN_GADV;
            ST_G_PRT:  a_reg = RN_GLPA;
            ST_F_LCL:  a_reg = RN_ADV;
            ST_F_PRT:  a_reg = RN_LPA;
            ST_DOWN: begin
                a_wr = 1'b1;
                a_wd = DATA_W'(s_q.sp) << B_SELHI;
            end
            default: acc = 1'b0;
        endcase
        a_phy = (s_q.st == ST_SCAN) ? s_q.scan : s_q.addr;
    end

    assign ack = acc && s_q.pend && mdio_ack;

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.done = 1'b0;

        if (acc && !s_q.pend) begin
            s_d.pend = 1'b1;
            s_d.req  = 1'b1;
            s_d.wr   = a_wr;
            s_d.phy  = a_phy;
            s_d.regn = a_reg;
            s_d.wd   = a_wd;
        end
        if (ack)
            s_d.pend = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.gb   = 1'b0;
                    s_d.sp   = 1'b0;
                    s_d.fd   = 1'b0;
                    s_d.fail = 1'b0;
                    s_d.scan = '0;
                    if (scan_en) begin
                        s_d.st = ST_SCAN;
                    end else begin
                        s_d.addr = dflt_addr;
                        s_d.st   = ST_RWAIT1;
                    end
                end
            end
            ST_SCAN: if (ack) begin
                if (rd != '0 && rd != ALL_ONES) begin
                    s_d.addr = s_q.scan;
                    s_d.st   = ST_RWAIT1;
                end else if (s_q.scan == SCAN_END) begin
                    s_d.addr = dflt_addr;
                    s_d.st   = ST_RWAIT1;
                end else begin
                    s_d.scan = s_q.scan + 1'b1;
                end
            end
            ST_RWAIT1: if (ack) begin
                if (rd[B_RST]) begin
                    if (tmr_exp) s_d.st = ST_FAIL;
                end else begin
                    s_d.ctl = rd;
                    s_d.st  = ST_RWR;
                end
            end
            ST_RWR: if (ack) s_d.st = ST_RWAIT2;
            ST_RWAIT2: if (ack) begin
                if (rd[B_RST]) begin
                    if (tmr_exp) s_d.st = ST_FAIL;
                end else begin
                    s_d.ctl = rd;
                    s_d.st  = rd[B_ANEN] ? ST_ANPOLL : ST_FORCE;
                end
            end
            ST_FORCE: if (ack) s_d.st = ST_FIN;
            ST_ANPOLL: if (ack) begin
                if (rd[B_ANOK])
                    s_d.st = rd[B_EXT] ? ST_G_LCL : ST_F_LCL;
                else if (tmr_exp)
                    s_d.st = ST_TORD;
            end
            ST_TORD: if (ack) begin
                s_d.gb = rd[B_SELLO] & ~rd[B_SELHI];
                s_d.sp = ~rd[B_SELLO] & rd[B_SELHI];
                s_d.fd = rd[B_DUP];
                s_d.st = ST_FIN;
            end
            ST_G_LCL: if (ack) begin
                s_d.abil = rd;
                s_d.st   = ST_G_PRT;
            end
            ST_G_PRT: if (ack) begin
                s_d.gb = gig_hit;
                s_d.fd = gig_fd;
                s_d.st = (gig_hit && mac_gbit) ? ST_FIN : ST_F_LCL;
            end
            ST_F_LCL: if (ack) begin
                s_d.abil = rd;
                s_d.st   = ST_F_PRT;
            end
            ST_F_PRT: if (ack) begin
                s_d.gb = fast_gb;
                s_d.sp = fast_sp;
                s_d.fd = fast_fd;
                s_d.st = need_down ? ST_DOWN : ST_FIN;
            end
            ST_DOWN: if (ack) s_d.st = ST_FIN;
            ST_FIN: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            ST_FAIL: begin
                s_d.done = 1'b1;
                s_d.fail = 1'b1;
                s_d.gb   = 1'b0;
                s_d.sp   = 1'b0;
                s_d.fd   = 1'b0;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdio_req   = s_q.req;
    assign mdio_wr    = s_q.wr;
    assign mdio_phy   = s_q.phy;
    assign mdio_reg   = s_q.regn;
    assign mdio_wdata = s_q.wd;
    assign done       = s_q.done;
    assign fail       = s_q.fail;
    assign phy_addr   = s_q.addr;
    assign mac_ctrl   = {s_q.gb, s_q.sp, 2'b00, s_q.fd, 4'b0000};

    // R10: a request is a single-cycle pulse
    a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |=> !mdio_req);

    // R10: no new request while one is waiting for its acknowledge
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !mdio_ack) |=> !mdio_req);

    // R10: request fields hold while the access is pending
    a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !mdio_req) |-> ($stable(mdio_phy) && $stable(mdio_reg)
                                     && $stable(mdio_wr) && $stable(mdio_wdata)));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a failure is only reached after the timer window ran out
    a_r3_fail_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FAIL) |-> tmr_exp);

    // R3: a failed run reports no mode
    a_r3_fail_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (mac_ctrl == 9'd0));

endmodule

// File: tb/test_phy_link_seq.sv
module test_phy_link_seq;

    localparam int TMO = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        scan_en = 1'b0;
    logic [4:0]  dflt_addr = '0;
    logic        mac_gbit = 1'b0;
    logic        mdio_req, mdio_wr;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_ack = 1'b0;
    logic        mdio_valid = 1'b0;
    logic [15:0] mdio_rdata = '0;
    logic        done, fail;
    logic [4:0]  phy_addr;
    logic [8:0]  mac_ctrl;

    int checks = 0;
    int fails = 0;

    // PHY model state
    int          m_phy;
    logic [15:0] m_r0, m_r1, m_r4, m_r5, m_r9, m_r10, m_rstwr;
    int          m_busy, m_rst_hold, m_an;
    int          m_viol = 0;
    int          m_reqs = 0;
    int          m_dones = 0;

    phy_link_seq #(.TIMEOUT_CYC(TMO), .SCAN_LAST(31)) i_phy_link_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en),
        .dflt_addr(dflt_addr), .mac_gbit(mac_gbit),
        .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack),
        .mdio_valid(mdio_valid), .mdio_rdata(mdio_rdata),
        .done(done), .fail(fail), .phy_addr(phy_addr), .mac_ctrl(mac_ctrl)
    );

    initial forever #2 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // management controller plus PHY register model
    initial begin
        forever begin
            @(negedge clk);
            if (mdio_req) begin
                logic [4:0]  cphy, creg;
                logic        cwr;
                logic [15:0] cwd, rdv;
                logic        vld;
                int          lat;
                cphy = mdio_phy; creg = mdio_reg; cwr = mdio_wr; cwd = mdio_wdata;
                m_reqs++;
                lat = 1 + $urandom_range(2);
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    if (mdio_req) m_viol++;
                    if (mdio_phy != cphy || mdio_reg != creg ||
                        mdio_wr != cwr || mdio_wdata != cwd) m_viol++;
                end
                rdv = 16'h0; vld = 1'b1;
                if (int'(cphy) != m_phy) begin
                    case (cphy % 3)
                        0: rdv = 16'h0000;
                        1: rdv = 16'hFFFF;
                        default: begin rdv = 16'h1234; vld = 1'b0; end
                    endcase
                end else if (cwr) begin
                    if (creg == 5'd0) begin
                        if (cwd[15]) begin
                            m_rstwr = cwd;
                            m_r0 = cwd & 16'h7FFF;
                            m_busy = m_rst_hold;
                        end else begin
                            m_r0 = cwd;
                        end
                    end
                end else begin
                    case (creg)
                        5'd0: begin
                            if (m_busy > 0) begin m_busy--; rdv = m_r0 | 16'h8000; end
                            else rdv = m_r0;
                        end
                        5'd1: begin
                            if (m_an > 0) begin m_an--; rdv = m_r1 & 16'hFFDF; end
                            else rdv = m_r1 | 16'h0020;
                        end
                        5'd4: rdv = m_r4;
                        5'd5: rdv = m_r5;
                        5'd9: rdv = m_r9;
                        5'd10: rdv = m_r10;
                        default: rdv = 16'h0;
                    endcase
                end
                mdio_rdata = rdv;
                mdio_valid = vld;
                mdio_ack = 1'b1;
                @(negedge clk);
                mdio_ack = 1'b0;
                mdio_valid = 1'b0;
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (done) m_dones++;
    end

    task automatic set_phy(int at, logic [15:0] r0, logic [15:0] r1,
                           logic [15:0] r4, logic [15:0] r5,
                           logic [15:0] r9, logic [15:0] r10,
                           int pre, int rsth, int an);
        m_phy = at; m_r0 = r0 & 16'h7FFF; m_r1 = r1; m_r4 = r4; m_r5 = r5;
        m_r9 = r9; m_r10 = r10; m_busy = pre; m_rst_hold = rsth; m_an = an;
        m_rstwr = 16'h0;
    endtask

    // expected outcome from the requirements
    task automatic run(string tag, bit scan, logic [4:0] dflt, bit mg, bit poke);
        logic [4:0]  e_addr;
        bit          e_fail, force0, down, tmo;
        logic        gb, sp, fd;
        logic [15:0] r0;
        int          e_ctrl, d0, q0, k;
        r0 = m_r0;
        e_addr = (scan && m_phy < 32) ? m_phy[4:0] : dflt;
        e_fail = (int'(e_addr) != m_phy) || (m_rst_hold > 5000) || (m_busy > 5000);
        gb = 0; sp = 0; fd = 0; force0 = 0; down = 0; tmo = 0;
        if (!e_fail) begin
            if (!r0[12]) force0 = 1;                         // R4
            else if (m_an > 5000) begin                      // R5
                tmo = 1;
                gb = r0[6] & ~r0[13]; sp = ~r0[6] & r0[13]; fd = r0[8];
            end else begin
                if (m_r1[8]) begin                           // R6
                    if (m_r9[9] && m_r10[11]) begin gb = 1; fd = 1; end
                    if (m_r9[8] && m_r10[10]) begin gb = 1; fd = 0; end
                end
                if (!gb || !mg) begin                        // R7
                    if (m_r4[8] && m_r5[8]) begin sp = 1; fd = 1; end
                    if (m_r4[7] && m_r5[7]) begin sp = 1; fd = 0; end
                    if (m_r4[6] && m_r5[6]) fd = 1;
                    if (gb && !mg) begin gb = 0; fd = 0; down = 1; end  // R8
                end
            end
        end
        e_ctrl = (int'(gb) << 8) | (int'(sp) << 7) | (int'(fd) << 4);
        m_viol = 0;
        d0 = m_dones;
        @(negedge clk);
        start = 1'b1; scan_en = scan; dflt_addr = dflt; mac_gbit = mg;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 30000) begin
            @(negedge clk);
            k++;
            if (poke && k == 15) start = 1'b1;
            if (poke && k == 16) start = 1'b0;
        end
        chk({tag, " R11 done seen"}, int'(done), 1);
        chk({tag, " R9 mac_ctrl"}, int'(mac_ctrl), e_ctrl);
        chk({tag, " R3 fail flag"}, int'(fail), int'(e_fail));
        chk({tag, " R1 phy_addr"}, int'(phy_addr), int'(e_addr));
        if (!e_fail) chk({tag, " R2 reset write"}, int'(m_rstwr), int'(r0 | 16'h8000));
        if (force0) chk({tag, " R4 reg0 cleared"}, int'(m_r0), 0);
        if (down) chk({tag, " R8 reg0 downgrade"}, int'(m_r0), int'(sp) << 13);
        if (tmo) chk({tag, " R5 timeout no fail"}, int'(fail), 0);
        chk({tag, " R10 handshake"}, m_viol, 0);
        q0 = m_reqs;
        repeat (30) @(negedge clk);
        chk({tag, " R11 single done"}, m_dones - d0, 1);
        chk({tag, " R11 outputs held"}, int'(mac_ctrl), e_ctrl);
        chk({tag, " R11 idle after"}, m_reqs - q0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_phy = 99; m_busy = 0; m_an = 0; m_rst_hold = 0;
        repeat (5) @(negedge clk);
        chk("R11 reset done", int'(done), 0);
        chk("R3 reset fail", int'(fail), 0);
        chk("R9 reset mac_ctrl", int'(mac_ctrl), 0);
        chk("R10 reset req", int'(mdio_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 + R4: found by scan, autoneg disabled
        set_phy(7, 16'h0141, 0, 0, 0, 0, 0, 2, 1, 0);
        run("dir_force", 1, 5'd3, 1, 0);
        // R6: gigabit full
        set_phy(3, 16'h1001, 16'h0100, 0, 0, 16'h0200, 16'h0800, 0, 2, 3);
        run("dir_gfull", 0, 5'd3, 1, 0);
        // R6: both gigabit abilities, half wins
        set_phy(3, 16'h1001, 16'h0100, 0, 0, 16'h0300, 16'h0C00, 0, 0, 0);
        run("dir_ghalf", 0, 5'd3, 1, 0);
        // R8: gigabit agreed, MAC not capable
        set_phy(12, 16'h1001, 16'h0100, 16'h0100, 16'h0100, 16'h0200, 16'h0800, 1, 1, 1);
        run("dir_down", 1, 5'd0, 0, 0);
        // R7: 100 half then 10 full override
        set_phy(2, 16'h1001, 16'h0000, 16'h01C0, 16'h00C0, 0, 0, 0, 0, 0);
        run("dir_fast", 0, 5'd2, 1, 0);
        // R5: negotiation timeout, 100 full from register 0
        set_phy(5, 16'h3101, 0, 16'h0100, 16'h0100, 0, 0, 0, 0, 100000);
        run("dir_to100", 1, 5'd1, 1, 0);
        // R5: negotiation timeout, gigabit from register 0
        set_phy(5, 16'h1141, 0, 0, 0, 0, 0, 0, 0, 100000);
        run("dir_tog", 1, 5'd1, 0, 0);
        // R3: reset never completes
        set_phy(6, 16'h1001, 0, 0, 0, 0, 0, 0, 100000, 0);
        run("dir_rstto", 1, 5'd1, 1, 0);
        // R1 + R3: no PHY anywhere, default 4 answers 0xFFFF
        set_phy(99, 16'h1001, 0, 0, 0, 0, 0, 0, 0, 0);
        run("dir_nophy", 1, 5'd4, 1, 0);
        // R11: start pulsed mid-run is ignored
        set_phy(9, 16'h1001, 16'h0100, 16'h0100, 16'h0100, 0, 0, 1, 2, 2);
        run("dir_poke", 1, 5'd0, 1, 1);

        for (int n = 0; n < 30; n++) begin
            logic [15:0] r0, r1;
            int at, an;
            bit sc;
            sc = $urandom_range(1);
            at = $urandom_range(31);
            r0 = 16'($urandom()) | 16'h0001;
            if ($urandom_range(3) != 0) r0 = r0 | 16'h1000;
            r1 = 16'($urandom()) & 16'h0101;
            an = ($urandom_range(7) == 0) ? 100000 : $urandom_range(4);
            set_phy(at, r0, r1, 16'($urandom()) & 16'h01C0, 16'($urandom()) & 16'h01C0,
                    16'($urandom()) & 16'h0300, 16'($urandom()) & 16'h0C00,
                    $urandom_range(2), $urandom_range(2), an);
            run($sformatf("rnd%0d", n), sc, at[4:0], 1'($urandom_range(1)), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule